// File: doc/BRIEF.md
# Sticky Debug Event Status Register

This block keeps a word of sticky status flags that record debug events. Each event input is a one-cycle pulse. While internal debug mode is on, a pulse sets its flag, and the flag stays set until software clears it. Software never loads data into the register. A write is a clear mask instead: every 1 in the written word clears that flag, and every 0 leaves it as it was. A small reset-reason field is captured from a reset-cause input while reset is held.

The block raises a level interrupt request when interrupts are enabled and at least one flag outside the informational group is set. The informational group is the reset-reason field, the offset flag and the variable-length-encoding flag.

When resource sharing is on, a per-bit ownership vector marks flags as hardware owned. Hardware-owned flags cannot be set by events and cannot be cleared by software writes.

Top module: `dbg_status_reg`

## Requirements
- R1: While `rst_n` is low, on every clock edge the register loads `rst_cause` into the reset-reason field (bits 31:30 at default parameters) and clears all other bits.
- R2: A write (`wr_en`=1) clears every status bit whose `wr_mask` bit is 1 and leaves every bit whose mask bit is 0 unchanged. The result is visible on `status` one clock after the write.
- R3: Event pulses set status bits only while `idm_en` is 1. With `idm_en` at 0 they have no effect.
- R4: A set status bit stays set on every following cycle until a permitted clear removes it.
- R5: If an event sets a bit in the same cycle that a write clears it, the bit ends up set.
- R6: With `irq_en`=1, `dbg_irq` is 1 exactly when some set bit lies outside the informational bits 31, 30, 1 and 0. Setting informational bits alone leaves `dbg_irq` at 0.
- R7: With `irq_en`=0, `dbg_irq` is 0 whatever the status.
- R8: With `share_en`=1, a write does not clear any bit whose `hw_own` bit is 1.
- R9: With `share_en`=1, an event does not set any bit whose `hw_own` bit is 1.
- R10: Event pulses at the reset-reason positions (bits 31:30) are ignored. `dbg_irq` follows `status` and `irq_en` in the same cycle, with no register between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_cause | input | 2 | Reset reason captured during reset |
| evt_pulse | input | 32 | One-cycle event pulses, one per status bit |
| idm_en | input | 1 | Internal debug mode enable; gates setting |
| share_en | input | 1 | Resource sharing enable |
| hw_own | input | 32 | 1 marks a bit as hardware owned |
| irq_en | input | 1 | Debug interrupt enable |
| wr_en | input | 1 | Software write strobe |
| wr_mask | input | 32 | Write data, used as a clear mask |
| status | output | 32 | Current status register value |
| dbg_irq | output | 1 | Debug interrupt request (level) |

## Verification
The bench builds the block with its default parameters: a 32-bit word, the reset-reason field at bits 31:30, the offset flag at bit 1 and the variable-length flag at bit 0. This placement puts the field at the top of the word and the two single flags at the bottom. A mask that is off by one at either end, or that drops a flag, therefore changes the interrupt outcome in the directed cases. Random cycles combine pulses, masks, ownership and mode bits in every combination. These cover set-versus-clear collisions on shared and hardware-owned bits together with the mode gates.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

    typedef struct packed {
        logic idm;
        logic share;
    } dsr_mode_t;

    function automatic logic [63:0] field_mask(input int lsb, input int width);
        logic [63:0] m;
        m = '0;
        for (int i = 0; i < 64; i++) begin
            if (i >= lsb && i < lsb + width) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [63:0] bit_mask(input int pos);
        logic [63:0] m;
        m = '0;
        m[pos] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/dsr_filter.sv
module dsr_filter
    import dsr_pkg::*;
#(
    parameter int W = 32,
    parameter logic [W-1:0] NOSET_MASK = '0
) (
    input  logic [W-1:0] evt_pulse,
    input  logic         wr_en,
    input  logic [W-1:0] wr_mask,
    input  logic [W-1:0] hw_own,
    input  dsr_mode_t    mode,
    output logic [W-1:0] set_eff,
    output logic [W-1:0] clr_eff
);

    logic [W-1:0] sw_allowed;

    always_comb begin
        sw_allowed = mode.share ? ~hw_own : {W{1'b1}};
        set_eff    = mode.idm ? (evt_pulse & ~NOSET_MASK & sw_allowed) : '0;
        clr_eff    = wr_en ? (wr_mask & sw_allowed) : '0;
    end

endmodule

// File: rtl/dsr_store.sv
module dsr_store #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rst_val,
    input  logic [W-1:0] set_eff,
    input  logic [W-1:0] clr_eff,
    output logic [W-1:0] q
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[i] <= rst_val[i];
            end else if (set_eff[i]) begin
                q[i] <= 1'b1;
            end else if (clr_eff[i]) begin
                q[i] <= 1'b0;
            end
        end
    end

    assert_reset_load_R1: assert property (@(posedge clk)
        !rst_n |=> (q == $past(rst_val)));

    assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q & $past(clr_eff & ~set_eff)) == '0));

    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q & $past(q & ~clr_eff)) == $past(q & ~clr_eff)));

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((q & $past(set_eff)) == $past(set_eff)));

endmodule

// File: rtl/dsr_irq.sv
module dsr_irq #(
    parameter int W = 32,
    parameter logic [W-1:0] INFO_MASK = '0
) (
    input  logic [W-1:0] status,
    input  logic         irq_en,
    output logic         irq
);

    logic [W-1:0] live;

    always_comb begin
        live = status & ~INFO_MASK;
        irq  = irq_en & (|live);
    end

    always_comb begin
        if (!irq_en) assert_irq_gated_R7: assert (!irq);
    end

endmodule

// File: rtl/dbg_status_reg.sv
module dbg_status_reg
    import dsr_pkg::*;
#(
    parameter int W       = 32,
    parameter int RR_LSB  = 30,
    parameter int RR_W    = 2,
    parameter int OFS_POS = 1,
    parameter int VLE_POS = 0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [RR_W-1:0] rst_cause,
    input  logic [W-1:0]    evt_pulse,
    input  logic            idm_en,
    input  logic            share_en,
    input  logic [W-1:0]    hw_own,
    input  logic            irq_en,
    input  logic            wr_en,
    input  logic [W-1:0]    wr_mask,
    output logic [W-1:0]    status,
    output logic            dbg_irq
);

    localparam logic [63:0] RR_FULL   = field_mask(RR_LSB, RR_W);
    localparam logic [63:0] INFO_FULL = RR_FULL | bit_mask(OFS_POS) | bit_mask(VLE_POS);
    localparam logic [W-1:0] RR_MASK   = RR_FULL[W-1:0];
    localparam logic [W-1:0] INFO_MASK = INFO_FULL[W-1:0];

    dsr_mode_t    mode;
    logic [W-1:0] set_eff;
    logic [W-1:0] clr_eff;
    logic [W-1:0] rst_val;

    always_comb begin
        mode.idm   = idm_en;
        mode.share = share_en;
        rst_val    = '0;
        rst_val[RR_LSB +: RR_W] = rst_cause;
    end

    dsr_filter #(
        .W          (W),
        .NOSET_MASK (RR_MASK)
    ) u_filter (
        .evt_pulse (evt_pulse),
        .wr_en     (wr_en),
        .wr_mask   (wr_mask),
        .hw_own    (hw_own),
        .mode      (mode),
        .set_eff   (set_eff),
        .clr_eff   (clr_eff)
    );

    dsr_store #(
        .W (W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_val (rst_val),
        .set_eff (set_eff),
        .clr_eff (clr_eff),
        .q       (status)
    );

    dsr_irq #(
        .W         (W),
        .INFO_MASK (INFO_MASK)
    ) u_irq (
        .status (status),
        .irq_en (irq_en),
        .irq    (dbg_irq)
    );

    assert_idm_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !idm_en |=> ((status & ~$past(status)) == '0));

    assert_info_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~INFO_MASK) == '0) |-> !dbg_irq);

    assert_live_raises_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && ((status & ~INFO_MASK) != '0)) |-> dbg_irq);

    assert_hw_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        share_en |=> ((($past(status) & ~status) & $past(hw_own)) == '0));

    assert_hw_noset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        share_en |=> (((status & ~$past(status)) & $past(hw_own)) == '0));

    assert_rr_noevt_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status & RR_MASK) == ($past(status) & RR_MASK & ~$past(clr_eff))));

endmodule

// File: tb/test_dbg_status_reg.sv
`timescale 1ns/1ps
module test_dbg_status_reg;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  rst_cause = 2'b10;
    logic [31:0] evt_pulse = '0;
    logic        idm_en = 1'b0;
    logic        share_en = 1'b0;
    logic [31:0] hw_own = '0;
    logic        irq_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_mask = '0;
    logic [31:0] status;
    logic        dbg_irq;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] exp_st;

    always #2.5 clk = ~clk;

    dbg_status_reg i_dbg_status_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .rst_cause (rst_cause),
        .evt_pulse (evt_pulse),
        .idm_en    (idm_en),
        .share_en  (share_en),
        .hw_own    (hw_own),
        .irq_en    (irq_en),
        .wr_en     (wr_en),
        .wr_mask   (wr_mask),
        .status    (status),
        .dbg_irq   (dbg_irq)
    );

    localparam logic [31:0] INFO = 32'hC000_0003;
    localparam logic [31:0] RRB  = 32'hC000_0000;

    function automatic logic [31:0] model_next(
        input logic [31:0] cur, input logic [31:0] ev, input logic idm,
        input logic sh, input logic [31:0] own, input logic we, input logic [31:0] wm);
        logic [31:0] ok, s, c;
        ok = sh ? ~own : 32'hFFFF_FFFF;
        s  = idm ? (ev & ~RRB & ok) : 32'h0;
        c  = we ? (wm & ok) : 32'h0;
        return s | (cur & ~c);
    endfunction

    function automatic logic model_irq(input logic [31:0] st, input logic en);
        return en && ((st & ~INFO) != 0);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag, input logic [31:0] ev, input logic idm,
                        input logic sh, input logic [31:0] own, input logic ien,
                        input logic we, input logic [31:0] wm);
        @(negedge clk);
        evt_pulse = ev; idm_en = idm; share_en = sh; hw_own = own;
        irq_en = ien; wr_en = we; wr_mask = wm;
        @(posedge clk);
        #1;
        exp_st = model_next(exp_st, ev, idm, sh, own, we, wm);
        check({tag, " status"}, status, exp_st);
        check({tag, " irq"}, {31'b0, dbg_irq}, {31'b0, model_irq(exp_st, ien)});
    endtask

    initial begin
        #(200000 * 5);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual running expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        irq_en = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        exp_st = 32'h8000_0000;
        check("R1 reset value", status, exp_st);
        check("R6 info-only irq", {31'b0, dbg_irq}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        step("R3 set with idm", 32'h0000_0F04, 1, 0, 0, 1, 0, 0);
        step("R2 mask clear", 0, 1, 0, 0, 1, 1, 32'h0000_0300);
        step("R3 idm off", 32'h00F0_0000, 0, 0, 0, 1, 0, 0);
        step("R4 hold", 0, 1, 0, 0, 1, 0, 0);
        step("R5 set wins", 32'h0000_0010, 1, 0, 0, 1, 1, 32'h0000_0010);
        step("R10 rr evt ignored", 32'hC000_0000, 1, 0, 0, 1, 0, 0);
        step("R6 clear live", 0, 1, 0, 0, 1, 1, 32'h3FFF_FFFC);
        step("R6 info bits", 32'h0000_0003, 1, 0, 0, 1, 0, 0);
        step("R6 live bit 2", 32'h0000_0004, 1, 0, 0, 1, 0, 0);
        step("R7 irq disabled", 32'h0000_0100, 1, 0, 0, 0, 0, 0);
        step("R8 hw bit kept", 0, 1, 1, 32'h0000_0100, 1, 1, 32'hFFFF_FFFF);
        step("R9 hw bit not set", 32'h0000_0600, 1, 1, 32'h0000_0200, 1, 0, 0);
        step("R10 irq follows en", 0, 1, 0, 0, 1, 0, 0);

        for (int k = 0; k < 3000; k++) begin
            step("R4 random", $urandom & $urandom & $urandom, 1'($urandom),
                 1'($urandom), $urandom, 1'($urandom % 4 != 0),
                 1'($urandom % 3 == 0), $urandom & $urandom);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule